// File: doc/BRIEF.md
# Framebuffer Span Copy Engine

This block runs one span-copy command on a 1280 x 1024 framebuffer. A start pulse gives it the word address of a command packet. The engine reads the packet one word at a time through a read port with one cycle of latency. The first word must carry the span-copy opcode. The second word holds the number of span descriptors in its top byte. Descriptors begin after a five-word header, and each descriptor is three words long. For every descriptor, the engine copies a run of pixels that starts at column 0 of a source row into the same columns of a destination row. The framebuffer port also has one cycle of read latency and moves one pixel per clock.

While the command runs, the engine keeps a bounding box of the rows it touched, so that a display refresh path can redraw only that region. Each accepted command starts with an empty box. Every descriptor widens the box to cover both its source row and its destination row, and sets the column range to the whole line. `busy` stays high for the whole command. A one-cycle `done` pulse follows, both for a command that ran and for one that was refused.

Top module: `spancopy_engine`

## Requirements
- R1: After reset, `busy`, `done`, `fb_rd_en`, `fb_wr_en`, `cmd_rd_en` and `dirty_valid` are all low.
- R2: Word 0 of the packet must equal exactly 0x00000405. Any other value is refused: no framebuffer write happens, the dirty box stays empty (`dirty_valid` low), and `done` still pulses.
- R3: The span count is bits 31:24 of packet word 1, and the other bits of word 1 are ignored. Words 2 to 4 are ignored. Descriptor k sits at words 5+3k (length), 6+3k (source) and 7+3k (destination), counted from `cmd_base`.
- R4: A descriptor's length, source and destination words are each shifted right by three. The length gives a pixel count N. The row numbers are bits 12:3 of the source and destination words, so a row number wraps modulo 1024. Pixels at columns 0 to N-1 of the source row are copied to the same columns of the destination row.
- R5: A shifted length greater than 1280 is clamped to 1280, so no column at 1280 or above is ever addressed.
- R6: Descriptors are executed strictly in list order. A later span reads the pixels that earlier spans of the same command wrote.
- R7: An accepted start empties the dirty box. Each descriptor, including one of length zero, widens `dirty_row_lo`/`dirty_row_hi` to cover both its source row and its destination row. It also sets `dirty_col_lo`=0 and `dirty_col_hi`=1279 and raises `dirty_valid`.
- R8: `busy` is high from the cycle after an accepted start until the last span has finished. `done` then pulses for exactly one cycle with `busy` low. A start pulse that arrives while `busy` is high is ignored.
- R9: A span count of zero finishes the command with no framebuffer write and an empty dirty box.
- R10: Within a span, one pixel is read per cycle at consecutive columns. Each write follows its read by one cycle, so a span of N pixels writes on N back-to-back cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that begins a command |
| cmd_base | input | CMD_AW | Word address of the packet |
| cmd_rd_en | output | 1 | Packet word read request |
| cmd_rd_addr | output | CMD_AW | Packet word address |
| cmd_rd_data | input | 32 | Packet word, valid one cycle after the request |
| fb_rd_en | output | 1 | Pixel read request |
| fb_rd_row | output | ROW_W | Pixel read row |
| fb_rd_col | output | COL_W | Pixel read column |
| fb_rd_data | input | PIX_W | Pixel data, valid one cycle after the request |
| fb_wr_en | output | 1 | Pixel write strobe |
| fb_wr_row | output | ROW_W | Pixel write row |
| fb_wr_col | output | COL_W | Pixel write column |
| fb_wr_data | output | PIX_W | Pixel write data |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| dirty_valid | output | 1 | Dirty box holds at least one span |
| dirty_row_lo | output | ROW_W | Lowest touched row |
| dirty_row_hi | output | ROW_W | Highest touched row |
| dirty_col_lo | output | COL_W | Lowest touched column |
| dirty_col_hi | output | COL_W | Highest touched column |

## Verification
The copy path is tried with several packet shapes:
- A lone short span with junk in the ignored header bits shows that the fields are picked from the right words and bit positions.
- A chain in which each span reads the previous span's destination row separates in-order execution from any reordering or prefetching of pixels.
- Descriptor words with set low bits and a source row past 1023 show that the shift and the row wrap are correct.
- An over-long length shows the clamp.
- A twelve-span list at a nonzero base exercises descriptor addressing far past the header.

Refused opcodes, a zero span count and a zero-length span separate "no pixels moved" from "dirty box untouched". A second start pulse during a run tests that the engine is deaf to start while busy.

// File: rtl/spancopy_pkg.sv
package spancopy_pkg;

  localparam logic [31:0] COPY_OPCODE = 32'h0000_0405;
  localparam int HDR_WORDS  = 5;
  localparam int DESC_WORDS = 3;
  localparam int FIELD_SHIFT = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_COUNT,
    ST_LEN,
    ST_SRC,
    ST_DST,
    ST_MOVE,
    ST_FINISH
  } ctrl_state_e;

endpackage

// File: rtl/spancopy_ctrl.sv
module spancopy_ctrl
  import spancopy_pkg::*;
#(
  parameter int CMD_AW = 16,
  parameter int XRES   = 1280,
  parameter int ROW_W  = 10,
  parameter int LEN_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CMD_AW-1:0] cmd_base,
  output logic              cmd_rd_en,
  output logic [CMD_AW-1:0] cmd_rd_addr,
  input  logic [31:0]       cmd_rd_data,
  output logic              busy,
  output logic              done,
  output logic              box_clear,
  output logic              box_upd,
  output logic [ROW_W-1:0]  box_row_a,
  output logic [ROW_W-1:0]  box_row_b,
  output logic              mv_go,
  output logic [ROW_W-1:0]  mv_src,
  output logic [ROW_W-1:0]  mv_dst,
  output logic [LEN_W-1:0]  mv_len,
  input  logic              mv_done
);

  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(XRES);

  ctrl_state_e       state_q, state_d;
  logic [CMD_AW-1:0] ptr_q, ptr_d;
  logic [7:0]        left_q, left_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [ROW_W-1:0]  src_q, src_d;
  logic              ptr_en, left_en, len_en, src_en;

  logic [31-FIELD_SHIFT:0] raw_len;
  logic [7:0]              span_cnt;
  logic [ROW_W-1:0]        row_field;

  assign raw_len   = cmd_rd_data[31:FIELD_SHIFT];
  assign span_cnt  = cmd_rd_data[31:24];
  assign row_field = cmd_rd_data[ROW_W+FIELD_SHIFT-1:FIELD_SHIFT];

  always_comb begin
    state_d     = state_q;
    ptr_d       = ptr_q;
    left_d      = left_q;
    len_d       = len_q;
    src_d       = src_q;
    cmd_rd_en   = 1'b0;
    cmd_rd_addr = ptr_q;
    box_clear   = 1'b0;
    box_upd     = 1'b0;
    mv_go       = 1'b0;
    done        = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          cmd_rd_en   = 1'b1;
          cmd_rd_addr = cmd_base;
          ptr_d       = cmd_base;
          box_clear   = 1'b1;
          state_d     = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (cmd_rd_data == COPY_OPCODE) begin
          cmd_rd_en   = 1'b1;
          cmd_rd_addr = ptr_q + CMD_AW'(1);
          state_d     = ST_COUNT;
        end else begin
          state_d = ST_FINISH;
        end
      end
      ST_COUNT: begin
        if (span_cnt == 8'd0) begin
          state_d = ST_FINISH;
        end else begin
          cmd_rd_en   = 1'b1;
          cmd_rd_addr = ptr_q + CMD_AW'(HDR_WORDS);
          ptr_d       = ptr_q + CMD_AW'(HDR_WORDS);
          left_d      = span_cnt;
          state_d     = ST_LEN;
        end
      end
      ST_LEN: begin
        len_d       = (raw_len > (32-FIELD_SHIFT)'(XRES)) ? MAX_LEN : LEN_W'(raw_len);
        cmd_rd_en   = 1'b1;
        cmd_rd_addr = ptr_q + CMD_AW'(1);
        state_d     = ST_SRC;
      end
      ST_SRC: begin
        src_d       = row_field;
        cmd_rd_en   = 1'b1;
        cmd_rd_addr = ptr_q + CMD_AW'(2);
        state_d     = ST_DST;
      end
      ST_DST: begin
        mv_go   = 1'b1;
        box_upd = 1'b1;
        ptr_d   = ptr_q + CMD_AW'(DESC_WORDS);
        state_d = ST_MOVE;
      end
      ST_MOVE: begin
        if (mv_done) begin
          left_d = left_q - 8'd1;
          if (left_q == 8'd1) begin
            state_d = ST_FINISH;
          end else begin
            cmd_rd_en   = 1'b1;
            cmd_rd_addr = ptr_q;
            state_d     = ST_LEN;
          end
        end
      end
      ST_FINISH: begin
        done    = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign ptr_en  = (ptr_d != ptr_q);
  assign left_en = (state_q == ST_COUNT) || (state_q == ST_MOVE);
  assign len_en  = (state_q == ST_LEN);
  assign src_en  = (state_q == ST_SRC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      left_q  <= '0;
      len_q   <= '0;
      src_q   <= '0;
    end else begin
      state_q <= state_d;
      if (ptr_en)  ptr_q  <= ptr_d;
      if (left_en) left_q <= left_d;
      if (len_en)  len_q  <= len_d;
      if (src_en)  src_q  <= src_d;
    end
  end

  assign busy      = (state_q != ST_IDLE) && (state_q != ST_FINISH);
  assign mv_src    = src_q;
  assign mv_dst    = row_field;
  assign mv_len    = len_q;
  assign box_row_a = src_q;
  assign box_row_b = row_field;

  p_done_not_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_busy_ends_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  p_len_clamped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mv_go |-> (mv_len <= MAX_LEN));

endmodule

// File: rtl/spancopy_mover.sv
module spancopy_mover #(
  parameter int XRES  = 1280,
  parameter int ROW_W = 10,
  parameter int COL_W = 11,
  parameter int LEN_W = 11,
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [ROW_W-1:0] src_row,
  input  logic [ROW_W-1:0] dst_row,
  input  logic [LEN_W-1:0] len,
  output logic             done,
  output logic             fb_rd_en,
  output logic [ROW_W-1:0] fb_rd_row,
  output logic [COL_W-1:0] fb_rd_col,
  input  logic [PIX_W-1:0] fb_rd_data,
  output logic             fb_wr_en,
  output logic [ROW_W-1:0] fb_wr_row,
  output logic [COL_W-1:0] fb_wr_col,
  output logic [PIX_W-1:0] fb_wr_data
);

  logic             act_q, act_d;
  logic [COL_W-1:0] col_q, col_d;
  logic [LEN_W-1:0] left_q, left_d;
  logic [ROW_W-1:0] src_q, dst_q;
  logic             wv_q, wv_d;
  logic [COL_W-1:0] wcol_q, wcol_d;
  logic             wlast_q, wlast_d;
  logic             zdone_q, zdone_d;
  logic             last_rd;

  assign last_rd = act_q && (left_q == LEN_W'(1));

  always_comb begin
    act_d   = act_q;
    col_d   = col_q;
    left_d  = left_q;
    zdone_d = 1'b0;
    if (go) begin
      if (len == '0) begin
        zdone_d = 1'b1;
      end else begin
        act_d  = 1'b1;
        col_d  = '0;
        left_d = len;
      end
    end else if (act_q) begin
      col_d  = col_q + COL_W'(1);
      left_d = left_q - LEN_W'(1);
      if (last_rd) act_d = 1'b0;
    end
    wv_d    = act_q;
    wcol_d  = col_q;
    wlast_d = last_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      col_q   <= '0;
      left_q  <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      wv_q    <= 1'b0;
      wcol_q  <= '0;
      wlast_q <= 1'b0;
      zdone_q <= 1'b0;
    end else begin
      act_q   <= act_d;
      col_q   <= col_d;
      left_q  <= left_d;
      if (go) begin
        src_q <= src_row;
        dst_q <= dst_row;
      end
      wv_q    <= wv_d;
      wcol_q  <= wcol_d;
      wlast_q <= wlast_d;
      zdone_q <= zdone_d;
    end
  end

  assign fb_rd_en   = act_q;
  assign fb_rd_row  = src_q;
  assign fb_rd_col  = col_q;
  assign fb_wr_en   = wv_q;
  assign fb_wr_row  = dst_q;
  assign fb_wr_col  = wcol_q;
  assign fb_wr_data = fb_rd_data;
  assign done       = (wv_q && wlast_q) || zdone_q;

  p_rd_col_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fb_rd_en |-> (fb_rd_col < COL_W'(XRES)));
  p_rd_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_rd_en && $past(fb_rd_en)) |-> (fb_rd_col == $past(fb_rd_col) + COL_W'(1)));
  p_wr_after_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fb_wr_en |-> $past(fb_rd_en));

endmodule

// File: rtl/spancopy_dirty.sv
module spancopy_dirty #(
  parameter int XRES  = 1280,
  parameter int ROW_W = 10,
  parameter int COL_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             upd,
  input  logic [ROW_W-1:0] row_a,
  input  logic [ROW_W-1:0] row_b,
  output logic             valid,
  output logic [ROW_W-1:0] row_lo,
  output logic [ROW_W-1:0] row_hi,
  output logic [COL_W-1:0] col_lo,
  output logic [COL_W-1:0] col_hi
);

  logic             valid_q, valid_d;
  logic [ROW_W-1:0] lo_q, lo_d, hi_q, hi_d;
  logic [COL_W-1:0] chi_q, chi_d;
  logic [ROW_W-1:0] pair_lo, pair_hi;
  logic             box_en;

  assign pair_lo = (row_a < row_b) ? row_a : row_b;
  assign pair_hi = (row_a < row_b) ? row_b : row_a;
  assign box_en  = clear || upd;

  always_comb begin
    valid_d = valid_q;
    lo_d    = lo_q;
    hi_d    = hi_q;
    chi_d   = chi_q;
    if (clear) begin
      valid_d = 1'b0;
      lo_d    = '0;
      hi_d    = '0;
      chi_d   = '0;
    end else if (upd) begin
      valid_d = 1'b1;
      chi_d   = COL_W'(XRES - 1);
      if (!valid_q) begin
        lo_d = pair_lo;
        hi_d = pair_hi;
      end else begin
        lo_d = (pair_lo < lo_q) ? pair_lo : lo_q;
        hi_d = (pair_hi > hi_q) ? pair_hi : hi_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      lo_q    <= '0;
      hi_q    <= '0;
      chi_q   <= '0;
    end else if (box_en) begin
      valid_q <= valid_d;
      lo_q    <= lo_d;
      hi_q    <= hi_d;
      chi_q   <= chi_d;
    end
  end

  assign valid  = valid_q;
  assign row_lo = lo_q;
  assign row_hi = hi_q;
  assign col_lo = '0;
  assign col_hi = chi_q;

  p_box_covers_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !clear) |=> (valid && row_lo <= $past(row_a) && row_hi >= $past(row_a)
                         && row_lo <= $past(row_b) && row_hi >= $past(row_b)));
  p_box_ordered_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (row_lo <= row_hi));

endmodule

// File: rtl/spancopy_engine.sv
module spancopy_engine
  import spancopy_pkg::*;
#(
  parameter int CMD_AW = 16,
  parameter int XRES   = 1280,
  parameter int YRES   = 1024,
  parameter int PIX_W  = 8,
  localparam int ROW_W = $clog2(YRES),
  localparam int COL_W = $clog2(XRES),
  localparam int LEN_W = $clog2(XRES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CMD_AW-1:0] cmd_base,
  output logic              cmd_rd_en,
  output logic [CMD_AW-1:0] cmd_rd_addr,
  input  logic [31:0]       cmd_rd_data,
  output logic              fb_rd_en,
  output logic [ROW_W-1:0]  fb_rd_row,
  output logic [COL_W-1:0]  fb_rd_col,
  input  logic [PIX_W-1:0]  fb_rd_data,
  output logic              fb_wr_en,
  output logic [ROW_W-1:0]  fb_wr_row,
  output logic [COL_W-1:0]  fb_wr_col,
  output logic [PIX_W-1:0]  fb_wr_data,
  output logic              busy,
  output logic              done,
  output logic              dirty_valid,
  output logic [ROW_W-1:0]  dirty_row_lo,
  output logic [ROW_W-1:0]  dirty_row_hi,
  output logic [COL_W-1:0]  dirty_col_lo,
  output logic [COL_W-1:0]  dirty_col_hi
);

  logic             box_clear, box_upd;
  logic [ROW_W-1:0] box_row_a, box_row_b;
  logic             mv_go, mv_done;
  logic [ROW_W-1:0] mv_src, mv_dst;
  logic [LEN_W-1:0] mv_len;

  spancopy_ctrl #(
    .CMD_AW(CMD_AW), .XRES(XRES), .ROW_W(ROW_W), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_base(cmd_base),
    .cmd_rd_en(cmd_rd_en), .cmd_rd_addr(cmd_rd_addr), .cmd_rd_data(cmd_rd_data),
    .busy(busy), .done(done),
    .box_clear(box_clear), .box_upd(box_upd),
    .box_row_a(box_row_a), .box_row_b(box_row_b),
    .mv_go(mv_go), .mv_src(mv_src), .mv_dst(mv_dst), .mv_len(mv_len),
    .mv_done(mv_done)
  );

  spancopy_mover #(
    .XRES(XRES), .ROW_W(ROW_W), .COL_W(COL_W), .LEN_W(LEN_W), .PIX_W(PIX_W)
  ) u_mover (
    .clk(clk), .rst_n(rst_n), .go(mv_go),
    .src_row(mv_src), .dst_row(mv_dst), .len(mv_len), .done(mv_done),
    .fb_rd_en(fb_rd_en), .fb_rd_row(fb_rd_row), .fb_rd_col(fb_rd_col),
    .fb_rd_data(fb_rd_data),
    .fb_wr_en(fb_wr_en), .fb_wr_row(fb_wr_row), .fb_wr_col(fb_wr_col),
    .fb_wr_data(fb_wr_data)
  );

  spancopy_dirty #(
    .XRES(XRES), .ROW_W(ROW_W), .COL_W(COL_W)
  ) u_dirty (
    .clk(clk), .rst_n(rst_n), .clear(box_clear), .upd(box_upd),
    .row_a(box_row_a), .row_b(box_row_b),
    .valid(dirty_valid), .row_lo(dirty_row_lo), .row_hi(dirty_row_hi),
    .col_lo(dirty_col_lo), .col_hi(dirty_col_hi)
  );

  p_write_needs_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fb_wr_en |-> busy);
  p_read_needs_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fb_rd_en |-> busy);

endmodule

// File: tb/sim_spancopy_engine.sv
module sim_spancopy_engine;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [15:0] cmd_base;
  logic        cmd_rd_en;
  logic [15:0] cmd_rd_addr;
  logic [31:0] cmd_rd_data;
  logic        fb_rd_en;
  logic [9:0]  fb_rd_row;
  logic [10:0] fb_rd_col;
  logic [7:0]  fb_rd_data;
  logic        fb_wr_en;
  logic [9:0]  fb_wr_row;
  logic [10:0] fb_wr_col;
  logic [7:0]  fb_wr_data;
  logic        busy, done, dirty_valid;
  logic [9:0]  dirty_row_lo, dirty_row_hi;
  logic [10:0] dirty_col_lo, dirty_col_hi;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  spancopy_engine u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_base(cmd_base),
    .cmd_rd_en(cmd_rd_en), .cmd_rd_addr(cmd_rd_addr), .cmd_rd_data(cmd_rd_data),
    .fb_rd_en(fb_rd_en), .fb_rd_row(fb_rd_row), .fb_rd_col(fb_rd_col),
    .fb_rd_data(fb_rd_data),
    .fb_wr_en(fb_wr_en), .fb_wr_row(fb_wr_row), .fb_wr_col(fb_wr_col),
    .fb_wr_data(fb_wr_data),
    .busy(busy), .done(done), .dirty_valid(dirty_valid),
    .dirty_row_lo(dirty_row_lo), .dirty_row_hi(dirty_row_hi),
    .dirty_col_lo(dirty_col_lo), .dirty_col_hi(dirty_col_hi)
  );

  logic [31:0] cmem   [int];
  logic [7:0]  fbm    [int];
  logic [7:0]  ref_fb [int];
  int cyc = 0, wr_cnt = 0, done_cnt = 0, first_wr = -1, last_wr = -1;
  bit e_valid;
  int e_lo, e_hi;

  function automatic logic [7:0] dflt(int key);
    return 8'((key / 2048) * 7 + (key % 2048) * 3 + 1);
  endfunction
  function automatic logic [7:0] act_get(int key);
    return fbm.exists(key) ? fbm[key] : dflt(key);
  endfunction
  function automatic logic [7:0] ref_get(int key);
    return ref_fb.exists(key) ? ref_fb[key] : dflt(key);
  endfunction

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cmd_rd_en)
      cmd_rd_data <= cmem.exists(int'(cmd_rd_addr)) ? cmem[int'(cmd_rd_addr)] : 32'h0;
    if (fb_rd_en)
      fb_rd_data <= act_get(int'(fb_rd_row) * 2048 + int'(fb_rd_col));
    if (fb_wr_en) begin
      fbm[int'(fb_wr_row) * 2048 + int'(fb_wr_col)] = fb_wr_data;
      wr_cnt = wr_cnt + 1;
      if (first_wr < 0) first_wr = cyc;
      last_wr = cyc;
    end
    if (done) done_cnt = done_cnt + 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic put_hdr(input int base, input logic [31:0] w0, input logic [31:0] w1);
    cmem[base]     = w0;
    cmem[base + 1] = w1;
    for (int i = 2; i < 5; i++) cmem[base + i] = 32'hFFFF_FFFF;
  endtask

  task automatic put_span(input int base, input int k,
                          input logic [31:0] l, input logic [31:0] s, input logic [31:0] d);
    cmem[base + 5 + 3 * k] = l;
    cmem[base + 6 + 3 * k] = s;
    cmem[base + 7 + 3 * k] = d;
  endtask

  task automatic model_span(input logic [31:0] l, input logic [31:0] s, input logic [31:0] d);
    int n = int'(l >> 3);
    int sr = int'((s >> 3) % 1024);
    int dr = int'((d >> 3) % 1024);
    logic [7:0] tmp [int];
    if (n > 1280) n = 1280;
    for (int c = 0; c < n; c++) tmp[c] = ref_get(sr * 2048 + c);
    for (int c = 0; c < n; c++) ref_fb[dr * 2048 + c] = tmp[c];
    if (!e_valid) begin
      e_lo = (sr < dr) ? sr : dr;
      e_hi = (sr < dr) ? dr : sr;
    end else begin
      if (sr < e_lo) e_lo = sr;
      if (dr < e_lo) e_lo = dr;
      if (sr > e_hi) e_hi = sr;
      if (dr > e_hi) e_hi = dr;
    end
    e_valid = 1'b1;
  endtask

  task automatic fresh();
    cmem.delete();
    fbm.delete();
    ref_fb.delete();
    e_valid = 1'b0;
    e_lo = 0;
    e_hi = 0;
  endtask

  task automatic run(input int base, input bit poke, input int alt_base, input string tag);
    int n = 0;
    @(negedge clk);
    wr_cnt = 0; done_cnt = 0; first_wr = -1; last_wr = -1;
    start = 1'b1;
    cmd_base = 16'(base);
    @(negedge clk);
    start = 1'b0;
    while (!done && n < 20000) begin
      if (poke && n == 3) begin
        start = 1'b1;
        cmd_base = 16'(alt_base);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    check(done == 1'b1, {tag, " R8 done seen"}, done, 1);
    check(busy == 1'b0, {tag, " R8 busy low with done"}, busy, 0);
    @(negedge clk);
    check(done == 1'b0 && done_cnt == 1, {tag, " R8 single done pulse"}, done_cnt, 1);
  endtask

  task automatic check_fb(input string tag);
    int bad = 0;
    foreach (ref_fb[k]) if (act_get(k) !== ref_fb[k]) bad++;
    foreach (fbm[k]) if (fbm[k] !== ref_get(k)) bad++;
    check(bad == 0, {tag, " pixel mismatches"}, bad, 0);
  endtask

  task automatic check_box(input string tag);
    check(dirty_valid == e_valid, {tag, " R7 dirty_valid"}, dirty_valid, e_valid);
    if (e_valid) begin
      check(int'(dirty_row_lo) == e_lo, {tag, " R7 row_lo"}, dirty_row_lo, e_lo);
      check(int'(dirty_row_hi) == e_hi, {tag, " R7 row_hi"}, dirty_row_hi, e_hi);
      check(dirty_col_lo == 11'd0 && dirty_col_hi == 11'd1279, {tag, " R7 col range"},
            dirty_col_hi, 1279);
    end
  endtask

  task automatic t_reset();
    check(!busy && !done && !fb_wr_en && !fb_rd_en && !cmd_rd_en && !dirty_valid,
          "R1 reset outputs", {busy, done, fb_wr_en, fb_rd_en, cmd_rd_en, dirty_valid}, 0);
  endtask

  task automatic t_single();
    fresh();
    put_hdr(0, 32'h405, 32'h01AB_CDEF);
    put_span(0, 0, 32'd16 << 3, 32'd3 << 3, 32'd10 << 3);
    model_span(32'd16 << 3, 32'd3 << 3, 32'd10 << 3);
    run(0, 1'b0, 0, "single");
    check_fb("R3 R4 single span");
    check(wr_cnt == 16, "R4 single write count", wr_cnt, 16);
    check(last_wr - first_wr == 15, "R10 back-to-back writes", last_wr - first_wr, 15);
    check_box("single");
  endtask

  task automatic t_ordered();
    fresh();
    put_hdr(0, 32'h405, 32'h0300_0000);
    put_span(0, 0, 32'd20 << 3, 32'd5 << 3, 32'd6 << 3);
    put_span(0, 1, 32'd20 << 3, 32'd6 << 3, 32'd7 << 3);
    put_span(0, 2, 32'd10 << 3, 32'd40 << 3, 32'd2 << 3);
    model_span(32'd20 << 3, 32'd5 << 3, 32'd6 << 3);
    model_span(32'd20 << 3, 32'd6 << 3, 32'd7 << 3);
    model_span(32'd10 << 3, 32'd40 << 3, 32'd2 << 3);
    put_hdr(200, 32'h405, 32'h0100_0000);
    put_span(200, 0, 32'd30 << 3, 32'd90 << 3, 32'd91 << 3);
    run(0, 1'b1, 200, "ordered");
    check_fb("R6 R8 ordered spans, start during busy ignored");
    check(wr_cnt == 50, "R6 ordered write count", wr_cnt, 50);
    check_box("ordered");
  endtask

  task automatic t_opcode();
    fresh();
    put_hdr(0, 32'h406, 32'h0100_0000);
    put_span(0, 0, 32'd8 << 3, 32'd1 << 3, 32'd2 << 3);
    run(0, 1'b0, 0, "bad opcode");
    check(wr_cnt == 0, "R2 no write for 0x406", wr_cnt, 0);
    check_box("R2 0x406");
    put_hdr(0, 32'h1405, 32'h0100_0000);
    run(0, 1'b0, 0, "upper bits");
    check(wr_cnt == 0, "R2 no write for 0x1405", wr_cnt, 0);
    check_box("R2 0x1405");
  endtask

  task automatic t_clamp();
    fresh();
    put_hdr(0, 32'h405, 32'h0100_0000);
    put_span(0, 0, 32'd2000 << 3, 32'd100 << 3, 32'd101 << 3);
    model_span(32'd2000 << 3, 32'd100 << 3, 32'd101 << 3);
    run(0, 1'b0, 0, "clamp");
    check(wr_cnt == 1280, "R5 clamp write count", wr_cnt, 1280);
    check_fb("R5 clamped span");
    check_box("clamp");
  endtask

  task automatic t_no_spans();
    fresh();
    put_hdr(0, 32'h405, 32'h00FF_FFFF);
    put_span(0, 0, 32'd8 << 3, 32'd1 << 3, 32'd2 << 3);
    run(0, 1'b0, 0, "no spans");
    check(wr_cnt == 0, "R9 zero count no write", wr_cnt, 0);
    check_box("R9 zero count");
  endtask

  task automatic t_zero_len();
    fresh();
    put_hdr(0, 32'h405, 32'h0100_0000);
    put_span(0, 0, 32'd7, 32'd20 << 3, 32'd30 << 3);
    model_span(32'd7, 32'd20 << 3, 32'd30 << 3);
    run(0, 1'b0, 0, "zero length");
    check(wr_cnt == 0, "R7 zero length no write", wr_cnt, 0);
    check_box("R7 zero length");
  endtask

  task automatic t_field_bits();
    logic [31:0] l = (32'd8 << 3) | 32'd5;
    logic [31:0] s = (32'd1030 << 3) | 32'd7;
    logic [31:0] d = (32'd50 << 3) | 32'd1;
    fresh();
    put_hdr(0, 32'h405, 32'h0100_0000);
    put_span(0, 0, l, s, d);
    model_span(l, s, d);
    run(0, 1'b0, 0, "field bits");
    check(wr_cnt == 8, "R4 shifted length", wr_cnt, 8);
    check_fb("R4 row wrap and low bits");
    check_box("R4 fields");
  endtask

  task automatic t_long_list();
    int expw = 0;
    fresh();
    put_hdr(1000, 32'h405, 32'h0C00_0000);
    for (int k = 0; k < 12; k++) begin
      logic [31:0] l = 32'((k * 37) % 90 + 1) << 3;
      logic [31:0] s = 32'((k * 61 + 9) % 1024) << 3;
      logic [31:0] d = 32'((k * 113 + 500) % 1024) << 3;
      put_span(1000, k, l, s, d);
      model_span(l, s, d);
      expw += (k * 37) % 90 + 1;
    end
    run(1000, 1'b0, 0, "long list");
    check(wr_cnt == expw, "R3 long list write count", wr_cnt, expw);
    check_fb("R3 R6 twelve spans");
    check_box("long list");
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    cmd_base = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_ordered();
    t_opcode();
    t_clamp();
    t_no_spans();
    t_zero_len();
    t_field_bits();
    t_long_list();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule